// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block produces the word address for a synchronous memory that supports four-word bursts. On a rising clock edge where a start strobe is active, it captures a 16-bit address from the bus. On later edges where the advance input is active, it moves to the next address of the burst by changing only the two least significant address bits. The upper fourteen bits do not change during a burst, and the low two bits wrap inside the aligned group of four words. A mode input selects one of two step orders: linear (add one, modulo four) or interleaved (the start offset XORed with a step count that runs 0, 1, 2, 3).

Two strobes can start a burst. The processor-side strobe takes effect only while chip select is active. The controller-side strobe loads the address whatever chip select is doing. Because an address can be loaded on any edge, a bus master that never advances gets a plain registered address with no added latency. Holding advance inactive keeps the address where it is, so the master can insert wait cycles. The memory array, the data path and write control belong to other blocks.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active, and after it is released, `addr_o` is 0 and `burst_act` is 0 until the first load.
- R2: When `adsc_n` is 0 at a rising edge, the value on `addr_i` appears on `addr_o` after that edge and `burst_act` becomes 1. The value of `cs_n` makes no difference.
- R3: When `adsp_n` is 0 and `cs_n` is 0 at an edge, the address is loaded in the same way as for R2. When `adsp_n` is 0 and `cs_n` is 1, the strobe is ignored and the cycle behaves as if no strobe were present. When both strobes are active, the address is loaded once and the step count restarts.
- R4: A load takes priority over an advance in the same cycle. Back-to-back loads on consecutive edges each show their own address.
- R5: At an edge with no load, the burst steps once if `adv_n` is 0 and a burst is active. If `adv_n` is 1, `addr_o` is held unchanged.
- R6: With `lbo_i` = 0 at load (linear order), the k-th step after a load with start offset s gives low bits (s + k) mod 4.
- R7: With `lbo_i` = 1 at load (interleaved order, the default for a strapped-high input), the k-th step gives low bits s XOR (k mod 4). For s = 1 the sequence is 1, 0, 3, 2.
- R8: Within a burst, `addr_o[15:2]` stays equal to the loaded `addr_i[15:2]`. After four steps the low bits return to the start offset.
- R9: Before any load after reset, `adv_n` = 0 has no effect: `addr_o` stays 0 and `burst_act` stays 0.
- R10: The step order is sampled only at a load. Changing `lbo_i` during a burst does not change the order of that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | External address captured on a load |
| adsp_n | input | 1 | Processor-side start strobe, active low, qualified by `cs_n` |
| adsc_n | input | 1 | Controller-side start strobe, active low, not qualified |
| cs_n | input | 1 | Chip select, active low, gates `adsp_n` only |
| adv_n | input | 1 | Advance, active low: 0 steps the burst, 1 holds it |
| lbo_i | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_o | output | 16 | Current word address |
| burst_act | output | 1 | 1 once a burst has been loaded |

## Verification
The bench starts bursts at all four start offsets in both orders and steps each burst past its fourth step. This catches a counter that carries into bit 2 or that wraps somewhere other than the start offset. It drives `adsp_n` with chip select inactive, and also both strobes in one cycle, which exposes a decoder that ignores the qualification or that double-steps. It sends advance before any load, inserts hold cycles in the middle of a burst, and toggles the order input mid-burst. A design that steps while idle, drifts while advance is inactive, or reads the order input on every cycle produces the wrong low bits in these cases. Random traffic mixes loads and advances on consecutive edges to test load-over-advance priority.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bag_strobe_dec.sv
module bag_strobe_dec (
  input  logic adsp_n,
  input  logic adsc_n,
  input  logic cs_n,
  output logic load_o
);
  logic proc_start;
  logic ctrl_start;

  always_comb begin
    proc_start = ~adsp_n & ~cs_n;
    ctrl_start = ~adsc_n;
    load_o     = proc_start | ctrl_start;
  end
endmodule

// File: rtl/bag_wrap_ctr.sv
module bag_wrap_ctr
  import bag_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_n,
  input  logic [CNT_W-1:0] start_i,
  input  logic             lbo_i,
  output logic [CNT_W-1:0] offset_o,
  output logic             act_o,
  output burst_order_e     ord_o
);
  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] seq_q,  seq_d;
  burst_order_e     ord_q,  ord_d;
  logic             act_q,  act_d;
  logic             step;

  always_comb begin
    step   = act_q & ~adv_n & ~load_i;
    base_d = base_q;
    seq_d  = seq_q;
    ord_d  = ord_q;
    act_d  = act_q;
    if (load_i) begin
      base_d = start_i;
      seq_d  = '0;
      ord_d  = burst_order_e'(lbo_i);
      act_d  = 1'b1;
    end else if (step) begin
      seq_d  = seq_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      seq_q  <= '0;
      ord_q  <= ORD_LINEAR;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      seq_q  <= seq_d;
      ord_q  <= ord_d;
      act_q  <= act_d;
    end
  end

  always_comb begin
    if (ord_q == ORD_INTERLEAVE) offset_o = base_q ^ seq_q;
    else                         offset_o = base_q + seq_q;
  end

  assign act_o = act_q;
  assign ord_o = ord_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              cs_n,
  input  logic              adv_n,
  input  logic              lbo_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_act
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic              load_w;
  logic [UP_W-1:0]   upper_q, upper_d;
  logic [CNT_W-1:0]  offset_w;
  burst_order_e      ord_w;

  bag_strobe_dec u_dec (
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .cs_n   (cs_n),
    .load_o (load_w)
  );

  bag_wrap_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_w),
    .adv_n    (adv_n),
    .start_i  (addr_i[CNT_W-1:0]),
    .lbo_i    (lbo_i),
    .offset_o (offset_w),
    .act_o    (burst_act),
    .ord_o    (ord_w)
  );

  always_comb begin
    upper_d = upper_q;
    if (load_w) upper_d = addr_i[ADDR_W-1:CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upper_q <= '0;
    else        upper_q <= upper_d;
  end

  assign addr_o = {upper_q, offset_w};
endmodule

// File: rtl/bag_checker.sv
module bag_checker
  import bag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              cs_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] addr_o,
  input logic              burst_act,
  input burst_order_e      ord
);
  logic no_start;
  assign no_start = adsc_n & (adsp_n | cs_n);

  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adsc_n |=> (addr_o == $past(addr_i)) && burst_act);

  p_proc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !cs_n) |=> addr_o == $past(addr_i));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (no_start && adv_n) |=> $stable(addr_o));

  p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (no_start && !adv_n && burst_act && ord == ORD_LINEAR)
      |=> addr_o[CNT_W-1:0] == $past(addr_o[CNT_W-1:0]) + 1'b1);

  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    no_start |=> addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W]));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (no_start && !burst_act) |=> !burst_act && $stable(addr_o));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (addr_o == '0 && !burst_act);
    end
  end
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .adsp_n    (adsp_n),
  .adsc_n    (adsc_n),
  .cs_n      (cs_n),
  .adv_n     (adv_n),
  .addr_o    (addr_o),
  .burst_act (burst_act),
  .ord       (ord_w)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr_i;
  logic        adsp_n, adsc_n, cs_n, adv_n, lbo_i;
  logic [15:0] addr_o;
  logic        burst_act;

  int n_tests = 0;
  int n_fail  = 0;

  logic [13:0] m_up;
  logic [1:0]  m_st;
  logic [1:0]  m_k;
  logic        m_md;
  logic        m_act;

  burst_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsp_n(adsp_n),
    .adsc_n(adsc_n), .cs_n(cs_n), .adv_n(adv_n), .lbo_i(lbo_i),
    .addr_o(addr_o), .burst_act(burst_act)
  );

  always #2 clk = ~clk;

  function automatic logic [1:0] exp_off(logic md, logic [1:0] s, logic [1:0] k);
    if (md) return s ^ k;
    return s + k;
  endfunction

  function automatic logic [15:0] exp_addr();
    return {m_up, exp_off(m_md, m_st, m_k)};
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_update();
    logic ld;
    ld = !adsc_n || (!adsp_n && !cs_n);
    if (ld) begin
      m_up = addr_i[15:2]; m_st = addr_i[1:0]; m_k = 2'd0;
      m_md = lbo_i; m_act = 1'b1;
    end else if (m_act && !adv_n) begin
      m_k = m_k + 2'd1;
    end
  endtask

  task automatic cyc(string tag, logic [15:0] a, logic psn, logic csn,
                     logic cn, logic avn, logic lb);
    addr_i = a; adsp_n = psn; cs_n = csn; adsc_n = cn; adv_n = avn; lbo_i = lb;
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(tag, addr_o, exp_addr());
    check(tag, {15'd0, burst_act}, {15'd0, m_act});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [15:0] mark;
    seed = 32'd1234;
    void'($urandom(seed));
    m_up = '0; m_st = '0; m_k = '0; m_md = 1'b0; m_act = 1'b0;
    rst_n = 1'b0; addr_i = 16'hFFFF; adsp_n = 1'b0; adsc_n = 1'b0;
    cs_n = 1'b0; adv_n = 1'b0; lbo_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset addr", addr_o, 16'h0000);
    check("R1 reset act", {15'd0, burst_act}, 16'd0);
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);

    // advance with no burst loaded, plus ADSP with chip deselected
    cyc("R9 idle advance", 16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc("R9 idle advance", 16'h5678, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    cyc("R3 adsp deselected", 16'hABCD, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R9 still zero", addr_o, 16'h0000);

    // all start offsets in both orders, stepped past wrap
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        logic [15:0] a;
        string tg;
        tg = md ? "R7 interleave" : "R6 linear";
        a = {14'h2A5C + 14'(s * 3 + md), 2'(s)};
        cyc("R2 adsc load", a, 1'b1, 1'b1, 1'b0, 1'b1, md[0]);
        check("R2 loaded", addr_o, a);
        for (int k = 1; k < 4; k++) begin
          cyc(tg, a, 1'b1, 1'b1, 1'b1, 1'b0, md[0]);
          check(tg, {14'd0, addr_o[1:0]},
                {14'd0, exp_off(md[0], 2'(s), 2'(k))});
          check("R8 upper fixed", {2'd0, addr_o[15:2]}, {2'd0, a[15:2]});
        end
        cyc("R8 wrap", a, 1'b1, 1'b1, 1'b1, 1'b0, md[0]);
        check("R8 wrap to start", addr_o, a);
      end
    end

    // explicit 1,0,3,2 sequence
    cyc("R7 seq", 16'h0041, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    cyc("R7 seq", 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 second", addr_o, 16'h0040);
    cyc("R7 seq", 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 third", addr_o, 16'h0043);
    cyc("R7 seq", 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 fourth", addr_o, 16'h0042);

    // hold cycles and mid-burst order change
    cyc("R5 load", 16'h7F01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    cyc("R5 step", 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    mark = addr_o;
    cyc("R5 hold", 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    cyc("R5 hold", 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R5 held", addr_o, mark);
    cyc("R10 lbo toggled", 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R10 still linear", addr_o, 16'h7F03);

    // both strobes, then load over advance, back-to-back loads
    cyc("R3 both strobes", 16'hC0DE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R3 single load", addr_o, 16'hC0DE);
    cyc("R4 load beats adv", 16'h1111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 first", addr_o, 16'h1111);
    cyc("R4 back to back", 16'h2222, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R4 second", addr_o, 16'h2222);
    cyc("R3 adsp gated mid burst", 16'h9999, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R3 gated steps", addr_o, 16'h2223);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      cyc("R5 random", r[15:0], r[16] | r[17], r[18], ~(r[19] & r[20] & r[21]),
          r[22] & r[23], r[24]);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule